// File: doc/BRIEF.md
# Buffered Handshake Pipeline Stage

This block is one registered stage of a streaming pipeline. Both sides use a valid/ready handshake. A word moves across a side only in a cycle where both valid and ready are high on that side. Between the two sides sits a small combinational operation: the stage adds a constant step to the operand. The step defaults to one, and the operand is 16 bits wide.

Upstream ready comes straight from a flop. To make that possible, the stage has a one-entry spill slot next to its output register. If the consumer stalls in the same cycle that a word is accepted, that word goes into the spill slot. While the slot is occupied, upstream ready is low. Nothing is dropped and nothing is sent twice.

Stages are meant to be chained directly. The output handshake of one stage connects to the input handshake of the next.

Top module: `hs_buf_stage`

## Requirements
- R1: A word is accepted only in a cycle where i_valid and o_ready are both high. A word is delivered only in a cycle where o_valid and i_ready are both high. If i_valid is high while o_ready is low, that input word never appears at the output.
- R2: o_valid is still low in the cycle that the first word is accepted. It is high in the following cycle.
- R3: Each delivered o_data equals the accepted i_data plus STEP, modulo 2^DATA_W. For example, 16'hFFFF plus 1 gives 16'h0000.
- R4: While o_valid is high and i_ready is low, o_valid stays high and o_data stays unchanged in the next cycle.
- R5: Suppose a word is accepted while the output word is stalled. That word is held in the spill slot. o_ready is low in the next cycle and stays low while the slot is occupied. The stage never holds more than two words: o_ready is never low while o_valid is low.
- R6: When the spill slot is occupied and the consumer takes the output word, the spilled word is the next one presented. o_ready is high again in the next cycle.
- R7: Suppose i_valid goes low and i_ready returns high. o_valid then stays high until every held word has been delivered, and falls in the cycle after the last delivery.
- R8: Words leave in the order they were accepted, under random send gaps and consumer stalls.
- R9: Two stages chained output-to-input add 2×STEP. A word accepted by the first stage appears at the second stage's output two cycles after acceptance, provided neither stage stalls.
- R10: A synchronous reset (rst high) clears o_valid and empties the spill slot. o_ready is high in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| i_valid | input | 1 | Upstream word present |
| i_data | input | DATA_W | Upstream operand |
| o_ready | output | 1 | Stage can take a word (registered) |
| o_valid | output | 1 | Output word present |
| o_data | output | DATA_W | Operand plus STEP |
| i_ready | input | 1 | Downstream can take a word |

## Verification
A word accepted at a rising edge shows up on o_valid/o_data right after that same edge, one register later. o_ready changes right after the edge at which the spill slot fills or empties. A chained pair adds one more edge.

The bench drives inputs just after each rising edge and samples the outputs at once, before the next edge. Every handshake it records is therefore one that the next edge will commit. A scoreboard queue of sent words plus the step is popped only on an observed output handshake. Directed checks of o_ready, o_valid and o_data are placed at the exact edge counts listed above.

// File: rtl/hs_buf_stage.sv
module hs_buf_stage #(
  parameter int DATA_W = 16,
  parameter int STEP   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              i_valid,
  input  logic [DATA_W-1:0] i_data,
  output logic              o_ready,
  output logic              o_valid,
  output logic [DATA_W-1:0] o_data,
  input  logic              i_ready
);
  localparam logic [DATA_W-1:0] StepV = DATA_W'(STEP);

  logic              spill_vld;
  logic [DATA_W-1:0] spill_dat;
  logic [DATA_W-1:0] result;
  logic              take_in;
  logic              out_free;

  assign result   = i_data + StepV;
  assign o_ready  = ~spill_vld;
  assign take_in  = i_valid & o_ready;
  assign out_free = ~o_valid | i_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid   <= 1'b0;
      spill_vld <= 1'b0;
    end else if (out_free) begin
      if (spill_vld) begin
        o_valid   <= 1'b1;
        spill_vld <= 1'b0;
      end else begin
        o_valid   <= take_in;
      end
    end else if (take_in) begin
      spill_vld <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (out_free) begin
      if (spill_vld)    o_data <= spill_dat;
      else if (take_in) o_data <= result;
    end
    if (!out_free && take_in) spill_dat <= result;
  end
endmodule

module hs_buf_stage_props #(
  parameter int DATA_W = 16,
  parameter int STEP   = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              i_valid,
  input logic [DATA_W-1:0] i_data,
  input logic              o_ready,
  input logic              o_valid,
  input logic [DATA_W-1:0] o_data,
  input logic              i_ready
);
  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !i_ready) |=> (o_valid && $stable(o_data)));

  a_r2_r3_first_word: assert property (@(posedge clk) disable iff (rst)
    (i_valid && o_ready && (!o_valid || i_ready)) |=>
      (o_valid && o_data == DATA_W'($past(i_data) + DATA_W'(STEP))));

  a_r5_two_words_max: assert property (@(posedge clk) disable iff (rst)
    !o_ready |-> o_valid);

  a_r5_spill_blocks: assert property (@(posedge clk) disable iff (rst)
    (i_valid && o_ready && o_valid && !i_ready) |=> !o_ready);

  a_r6_spill_drains: assert property (@(posedge clk) disable iff (rst)
    (!o_ready && i_ready) |=> (o_ready && o_valid));

  a_r7_fall_after_take: assert property (@(posedge clk) disable iff (rst)
    $fell(o_valid) |-> $past(i_ready));

  a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (o_ready && !o_valid));
endmodule

bind hs_buf_stage hs_buf_stage_props #(.DATA_W(DATA_W), .STEP(STEP)) u_props (
  .clk(clk), .rst(rst), .i_valid(i_valid), .i_data(i_data),
  .o_ready(o_ready), .o_valid(o_valid), .o_data(o_data), .i_ready(i_ready)
);

// File: tb/test_hs_buf_stage.sv
module test_hs_buf_stage;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        iv, ir, ordy, ov;
  logic [15:0] id, od;

  hs_buf_stage #(.DATA_W(16), .STEP(1)) i_hs_buf_stage (
    .clk(clk), .rst(rst), .i_valid(iv), .i_data(id),
    .o_ready(ordy), .o_valid(ov), .o_data(od), .i_ready(ir));

  logic        cv, cr, c_rdy, mid_v, mid_r, c_ov;
  logic [15:0] cd, mid_d, c_od;

  hs_buf_stage #(.DATA_W(16), .STEP(1)) i_hs_buf_stage_s1 (
    .clk(clk), .rst(rst), .i_valid(cv), .i_data(cd),
    .o_ready(c_rdy), .o_valid(mid_v), .o_data(mid_d), .i_ready(mid_r));
  hs_buf_stage #(.DATA_W(16), .STEP(1)) i_hs_buf_stage_s2 (
    .clk(clk), .rst(rst), .i_valid(mid_v), .i_data(mid_d),
    .o_ready(mid_r), .o_valid(c_ov), .o_data(c_od), .i_ready(cr));

  int checks = 0;
  int fails  = 0;
  logic [15:0] sb[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic step(input logic v, input logic [15:0] d, input logic r);
    iv = v; id = d; ir = r;
    #0;
    if (iv && ordy) sb.push_back(d + 16'd1);
    if (ov && ir) begin
      if (sb.size() == 0) chk(0, "R1/R8 unexpected word", od, 0);
      else begin
        logic [15:0] e;
        e = sb.pop_front();
        chk(od == e, "R3/R8 payload", od, e);
      end
    end
    tick();
  endtask

  task automatic do_reset();
    rst = 1'b1; iv = 0; ir = 0; id = 0; cv = 0; cr = 0; cd = 0;
    tick(); tick();
    rst = 1'b0;
    sb.delete();
  endtask

  task automatic t_reset();
    do_reset();
    chk(ov == 1'b0, "R10 o_valid after reset", ov, 0);
    chk(ordy == 1'b1, "R10 o_ready after reset", ordy, 1);
    step(1, 16'h0010, 0);
    step(1, 16'h0011, 0);
    chk(ordy == 1'b0, "R5 full before reset", ordy, 0);
    rst = 1'b1; iv = 0;
    tick();
    rst = 1'b0;
    chk(ov == 1'b0 && ordy == 1'b1, "R10 reset mid-stream", {ov, ordy}, 1);
    sb.delete();
  endtask

  task automatic t_latency();
    do_reset();
    iv = 1; id = 16'd5; ir = 1;
    #0;
    chk(ov == 1'b0, "R2 not same cycle", ov, 0);
    step(1, 16'd5, 1);
    chk(ov == 1'b1, "R2 valid next cycle", ov, 1);
    chk(od == 16'd6, "R3 plus one", od, 6);
    step(1, 16'hFFFF, 1);
    chk(od == 16'h0000, "R3 wrap", od, 0);
    step(0, 16'h0, 1);
    chk(ov == 1'b0 && sb.size() == 0, "R7 empty", ov, 0);
  endtask

  task automatic t_stall();
    do_reset();
    step(1, 16'd5, 1);
    step(1, 16'd7, 1);
    step(1, 16'd2, 1);
    step(1, 16'd9, 0);
    chk(ordy == 1'b0, "R5 spill holds", ordy, 0);
    chk(od == 16'd3, "R4 output held", od, 3);
    step(1, 16'hAAAA, 0);
    chk(ordy == 1'b0, "R5 still full", ordy, 0);
    chk(ov == 1'b1 && od == 16'd3, "R4 stable over stall", od, 3);
    step(0, 16'd12, 1);
    chk(ov == 1'b1 && od == 16'd10, "R6 spilled next", od, 10);
    chk(ordy == 1'b1, "R6 ready returns", ordy, 1);
    step(0, 16'd32, 1);
    chk(ov == 1'b0, "R7 falls after last", ov, 0);
    chk(sb.size() == 0, "R1 rejected word absent", sb.size(), 0);
  endtask

  task automatic t_random();
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] d;
      logic s, r;
      d = 16'($urandom);
      s = ($urandom % 4) != 0;
      r = ($urandom % 3) != 0;
      if (iv && !ordy) begin
        d = id; s = 1'b1;
      end
      step(s, d, r);
    end
    for (int n = 0; n < 4; n++) step(0, 16'h0, 1);
    chk(ov == 1'b0, "R7 random drain", ov, 0);
    chk(sb.size() == 0, "R8 all delivered in order", sb.size(), 0);
  endtask

  task automatic t_chain();
    do_reset();
    cv = 1; cd = 16'h0100; cr = 1;
    tick();
    cv = 0;
    chk(c_ov == 1'b0, "R9 not after one edge", c_ov, 0);
    tick();
    chk(c_ov == 1'b1, "R9 valid after two edges", c_ov, 1);
    chk(c_od == 16'h0102, "R9 plus two", c_od, 16'h0102);
    cv = 1; cd = 16'h0200; cr = 0;
    tick();
    cd = 16'h0300;
    tick();
    cv = 0;
    tick();
    chk(c_ov == 1'b1 && c_od == 16'h0102, "R9 chain stall hold", c_od, 16'h0102);
    cr = 1;
    #0;
    tick();
    chk(c_od == 16'h0202, "R9 order first", c_od, 16'h0202);
    tick();
    chk(c_od == 16'h0302, "R9 order second", c_od, 16'h0302);
    tick();
    chk(c_ov == 1'b0, "R9 chain drained", c_ov, 0);
  endtask

  initial begin
    iv = 0; ir = 0; id = 0; cv = 0; cr = 0; cd = 0;
    t_reset();
    t_latency();
    t_stall();
    t_random();
    t_chain();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule